// File: doc/BRIEF.md
# Branch record filter and compactor

This block holds a snapshot of up to `DEPTH` branch records. Each record carries a source address, a target address, an in-transaction flag, an abort flag and a classified branch-type vector. Records arrive one at a time through an append port, newest first. A start strobe then applies a requested-type mask. Every record whose type is not fully covered by the mask is discarded. The survivors are shifted down so that they sit in consecutive slots in their original order, and the new record count is reported.

Classification of the branches happens upstream: the type vector arrives with each record. The filter has two shortcuts. When the mask already accepts every privilege level and every branch category, the run finishes at once with nothing changed. When no record is discarded, the compaction pass is skipped. Otherwise, a read cursor and a write cursor walk the array, moving at most one record per clock.

An optional duplicate-abort correction applies at load time. Some record sources emit an abort twice, so when the correction is on, an incoming abort record replaces the record loaded just before it instead of being appended.

Top module: `brf_filter_compact`

## Requirements
- R1: A load with `ld_first` high writes slot 0 and sets the count to 1. Any other load writes the slot equal to the count and increments it. A load while the count equals `DEPTH` is ignored.
- R2: When `dup_abort_en` is high, a load with `ld_abort` high and a base count (0 if `ld_first`, else the count) above zero writes slot base−1 and leaves the count at base. When `dup_abort_en` is low, abort records append like any other load.
- R3: If the mask has all of type bits 0–12, 15 and 17 set, then `done` rises on the edge that accepts `start`, and the count and all records are unchanged. The value of bits 13, 14 and 16 does not matter for this test.
- R4: Type bits are: 0 user target, 1 kernel target, 2 call, 3 return, 4 system call, 5 system return, 6 software interrupt, 7 interrupt return, 8 conditional, 9 jump, 10 hardware interrupt, 11 indirect call, 12 abort, 13 in-transaction, 14 not-in-transaction, 15 zero-length call, 16 call stack, 17 indirect jump. A record is kept only if every bit of its effective type is also set in the mask.
- R5: When mask bit 13 or bit 14 is set, a record with a nonzero type is matched with bit 13 added if its in-transaction flag is 1, or with bit 14 added if the flag is 0.
- R6: A record whose type is zero is always discarded.
- R7: If no record within the count is discarded, `done` rises on the edge that accepts `start`, and the count and records are unchanged. This includes records whose source address is zero.
- R8: When compaction runs, discarded records and records with a zero source address are removed. The survivors occupy slots 0 onward in their original relative order, and the count becomes the number of survivors.
- R9: When compaction runs, `done` rises exactly (original count) edges after the edge that accepts `start`. `done` is high for a single cycle only.
- R10: While compaction runs, `start` and `ld_valid` have no effect.
- R11: The read port returns all zeros for any index at or beyond the count.
- R12: After reset, the count is 0, `done` is low and the read port returns zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Append one record |
| ld_first | input | 1 | Record starts a new snapshot |
| ld_from | input | ADDR_W | Source address of the record |
| ld_to | input | ADDR_W | Target address of the record |
| ld_intx | input | 1 | Record was taken inside a transaction |
| ld_abort | input | 1 | Record is a transaction abort |
| ld_type | input | 18 | Classified branch-type vector |
| dup_abort_en | input | 1 | Abort record overwrites the previous record |
| start | input | 1 | Begin a filter run |
| req_mask | input | 18 | Requested-type mask |
| done | output | 1 | One-cycle completion pulse |
| count | output | $clog2(DEPTH+1) | Records currently held |
| rd_idx | input | $clog2(DEPTH) | Read slot |
| rd_from | output | ADDR_W | Source address at the read slot |
| rd_to | output | ADDR_W | Target address at the read slot |
| rd_intx | output | 1 | In-transaction flag at the read slot |
| rd_abort | output | 1 | Abort flag at the read slot |
| rd_type | output | 18 | Type vector at the read slot |

## Verification
The bench instantiates the block with `DEPTH` = 8 and `ADDR_W` = 16. The small depth lets ten loads overrun the array, which exercises the ignored-load rule. It also lets a fully loaded array with alternating survivors run the worst-case eight-cycle compaction. A second start and a load are injected into the middle of that run. The narrow addresses keep every record, packed, within a 64-bit compare, so each slot is checked in one step.

// File: rtl/brf_pkg.sv
`timescale 1ns/1ps
package brf_pkg;
    localparam int TYPE_W   = 18;
    localparam int B_INTX   = 13;
    localparam int B_NOTX   = 14;
    // every privilege and every branch category; tx tags and call-stack excluded
    localparam logic [TYPE_W-1:0] TY_ALL = 18'h29FFF;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_MOVE = 1'b1} st_e;
endpackage

// File: rtl/brf_match.sv
`timescale 1ns/1ps
module brf_match
    import brf_pkg::*;
(
    input  logic [TYPE_W-1:0] typ,
    input  logic              intx,
    input  logic [TYPE_W-1:0] req,
    output logic              keep
);
    logic [TYPE_W-1:0] eff;

    always_comb begin
        eff = typ;
        if (typ != '0 && (req[B_INTX] || req[B_NOTX])) begin
            if (intx) eff[B_INTX] = 1'b1;
            else      eff[B_NOTX] = 1'b1;
        end
        keep = (eff != '0) && ((req & eff) == eff);
    end
endmodule

// File: rtl/brf_readmux.sv
`timescale 1ns/1ps
module brf_readmux
    import brf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0] from_a,
    input  logic [DEPTH-1:0][ADDR_W-1:0] to_a,
    input  logic [DEPTH-1:0]             tx_a,
    input  logic [DEPTH-1:0]             ab_a,
    input  logic [DEPTH-1:0][TYPE_W-1:0] ty_a,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [IDX_W-1:0]             idx,
    output logic [ADDR_W-1:0]            o_from,
    output logic [ADDR_W-1:0]            o_to,
    output logic                         o_intx,
    output logic                         o_abort,
    output logic [TYPE_W-1:0]            o_type
);
    logic hit;

    always_comb begin
        hit     = CNT_W'(idx) < cnt;
        o_from  = hit ? from_a[idx] : '0;
        o_to    = hit ? to_a[idx]   : '0;
        o_intx  = hit & tx_a[idx];
        o_abort = hit & ab_a[idx];
        o_type  = hit ? ty_a[idx]   : '0;
    end
endmodule

// File: rtl/brf_filter_compact.sv
`timescale 1ns/1ps
module brf_filter_compact
    import brf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 48,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              ld_first,
    input  logic [ADDR_W-1:0] ld_from,
    input  logic [ADDR_W-1:0] ld_to,
    input  logic              ld_intx,
    input  logic              ld_abort,
    input  logic [TYPE_W-1:0] ld_type,
    input  logic              dup_abort_en,
    input  logic              start,
    input  logic [TYPE_W-1:0] req_mask,
    output logic              done,
    output logic [CNT_W-1:0]  count,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_from,
    output logic [ADDR_W-1:0] rd_to,
    output logic              rd_intx,
    output logic              rd_abort,
    output logic [TYPE_W-1:0] rd_type
);
    typedef struct packed {
        st_e              st;
        logic [CNT_W-1:0] rp;
        logic [CNT_W-1:0] wp;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [DEPTH-1:0][ADDR_W-1:0] from_d, from_q, to_d, to_q;
    logic [DEPTH-1:0][TYPE_W-1:0] ty_d, ty_q;
    logic [DEPTH-1:0]             tx_d, tx_q, ab_d, ab_q;

    logic [DEPTH-1:0] keep, drop;
    logic             full_req;

    // per-slot match, all slots in parallel
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        brf_match u_m (
            .typ  (ty_q[g]),
            .intx (tx_q[g]),
            .req  (req_mask),
            .keep (keep[g])
        );
        assign drop[g] = (CNT_W'(g) < ctl_q.cnt) && !keep[g];
    end

    assign full_req = (req_mask & TY_ALL) == TY_ALL;

    // append slot selection
    logic [CNT_W-1:0] base, ld_cnt;
    logic [IDX_W-1:0] slot;
    logic             ld_ok;

    always_comb begin
        base = ld_first ? '0 : ctl_q.cnt;
        if (dup_abort_en && ld_abort && base != '0) begin
            ld_ok  = 1'b1;
            slot   = IDX_W'(base - 1'b1);
            ld_cnt = base;
        end else if (base < CNT_W'(DEPTH)) begin
            ld_ok  = 1'b1;
            slot   = IDX_W'(base);
            ld_cnt = base + 1'b1;
        end else begin
            ld_ok  = 1'b0;
            slot   = '0;
            ld_cnt = base;
        end
    end

    logic [IDX_W-1:0] rd_c, wr_c;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        from_d     = from_q;
        to_d       = to_q;
        ty_d       = ty_q;
        tx_d       = tx_q;
        ab_d       = ab_q;
        rd_c       = ctl_q.rp[IDX_W-1:0];
        wr_c       = ctl_q.wp[IDX_W-1:0];
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (full_req || drop == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        for (int i = 0; i < DEPTH; i++)
                            if (drop[i]) from_d[i] = '0;
                        ctl_d.st = ST_MOVE;
                        ctl_d.rp = '0;
                        ctl_d.wp = '0;
                    end
                end else if (ld_valid && ld_ok) begin
                    from_d[slot] = ld_from;
                    to_d[slot]   = ld_to;
                    ty_d[slot]   = ld_type;
                    tx_d[slot]   = ld_intx;
                    ab_d[slot]   = ld_abort;
                    ctl_d.cnt    = ld_cnt;
                end
            end
            ST_MOVE: begin
                if (from_q[rd_c] != '0) begin
                    from_d[wr_c] = from_q[rd_c];
                    to_d[wr_c]   = to_q[rd_c];
                    ty_d[wr_c]   = ty_q[rd_c];
                    tx_d[wr_c]   = tx_q[rd_c];
                    ab_d[wr_c]   = ab_q[rd_c];
                    ctl_d.wp     = ctl_q.wp + 1'b1;
                end
                ctl_d.rp = ctl_q.rp + 1'b1;
                if (ctl_q.rp == ctl_q.cnt - 1'b1) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.cnt  = ctl_d.wp;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            from_q <= '0;
            to_q   <= '0;
            ty_q   <= '0;
            tx_q   <= '0;
            ab_q   <= '0;
        end else begin
            ctl_q  <= ctl_d;
            from_q <= from_d;
            to_q   <= to_d;
            ty_q   <= ty_d;
            tx_q   <= tx_d;
            ab_q   <= ab_d;
        end
    end

    assign done  = ctl_q.done;
    assign count = ctl_q.cnt;

    brf_readmux #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_rd (
        .from_a (from_q),
        .to_a   (to_q),
        .tx_a   (tx_q),
        .ab_a   (ab_q),
        .ty_a   (ty_q),
        .cnt    (ctl_q.cnt),
        .idx    (rd_idx),
        .o_from (rd_from),
        .o_to   (rd_to),
        .o_intx (rd_intx),
        .o_abort(rd_abort),
        .o_type (rd_type)
    );

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= CNT_W'(DEPTH));

    // R8
    ptr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_MOVE) |-> (ctl_q.wp <= ctl_q.rp));

    // R8
    count_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count <= $past(count)));

    // R9
    move_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_MOVE) |-> !done);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_MOVE && (start || ld_valid)) |=> (ctl_q.st == ST_MOVE || done));
endmodule

// File: tb/sim_brf_filter_compact.sv
`timescale 1ns/1ps
module sim_brf_filter_compact;
    import brf_pkg::*;

    localparam int DEPTH  = 8;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 3;
    localparam int CNT_W  = 4;

    localparam logic [TYPE_W-1:0] TU    = 18'h00001;
    localparam logic [TYPE_W-1:0] TK    = 18'h00002;
    localparam logic [TYPE_W-1:0] TRET  = 18'h00008;
    localparam logic [TYPE_W-1:0] TCOND = 18'h00100;
    localparam logic [TYPE_W-1:0] TJMP  = 18'h00200;
    localparam logic [TYPE_W-1:0] TINTX = 18'h02000;
    localparam logic [TYPE_W-1:0] FULLM = 18'h29FFF;

    logic clk = 1'b0;
    logic rst_n;
    logic ld_valid, ld_first, ld_intx, ld_abort, dup_abort_en, start;
    logic [ADDR_W-1:0] ld_from, ld_to;
    logic [TYPE_W-1:0] ld_type, req_mask;
    logic done;
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] rd_idx;
    logic [ADDR_W-1:0] rd_from, rd_to;
    logic rd_intx, rd_abort;
    logic [TYPE_W-1:0] rd_type;

    always #2.5 clk = ~clk;

    brf_filter_compact #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_first(ld_first),
        .ld_from(ld_from), .ld_to(ld_to), .ld_intx(ld_intx), .ld_abort(ld_abort),
        .ld_type(ld_type), .dup_abort_en(dup_abort_en), .start(start),
        .req_mask(req_mask), .done(done), .count(count), .rd_idx(rd_idx),
        .rd_from(rd_from), .rd_to(rd_to), .rd_intx(rd_intx), .rd_abort(rd_abort),
        .rd_type(rd_type)
    );

    typedef struct packed {
        logic [ADDR_W-1:0] f;
        logic [ADDR_W-1:0] t;
        logic              x;
        logic              a;
        logic [TYPE_W-1:0] y;
    } rec_t;

    rec_t  mdl [DEPTH];
    int    m_cnt = 0;
    rec_t  exp_q[$];
    int    ecnt_q[$];
    int    elat_q[$];
    string etag_q[$];
    int    total = 0, bad = 0, pending = 0, cyc = 0, start_cyc = 0;
    bit    finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit mkeep(rec_t r, logic [TYPE_W-1:0] m);
        logic [TYPE_W-1:0] e;
        e = r.y;
        if (r.y != '0 && (m[13] || m[14])) e = e | (r.x ? 18'h02000 : 18'h04000);
        return (e != '0) && ((m & e) == e);
    endfunction

    task automatic ld(bit first, logic [ADDR_W-1:0] f, bit x, bit a, logic [TYPE_W-1:0] y);
        int base, slot;
        @(negedge clk);
        ld_valid = 1; ld_first = first; ld_from = f; ld_to = f + 16'h4000;
        ld_intx = x; ld_abort = a; ld_type = y;
        @(posedge clk);
        #1 ld_valid = 0; ld_first = 0;
        base = first ? 0 : m_cnt;
        if (dup_abort_en && a && base > 0) begin slot = base - 1; m_cnt = base; end
        else if (base < DEPTH) begin slot = base; m_cnt = base + 1; end
        else slot = -1;
        if (slot >= 0) mdl[slot] = '{f, f + 16'h4000, x, a, y};
    endtask

    // driver: predicts the outcome, queues it, then fires the run
    task automatic run(logic [TYPE_W-1:0] m, string tag, bit poke);
        rec_t nl[$];
        bit anyd;
        int lat;
        anyd = 0;
        for (int i = 0; i < m_cnt; i++) if (!mkeep(mdl[i], m)) anyd = 1;
        if (((m & FULLM) == FULLM) || !anyd) begin
            lat = 0;
            for (int i = 0; i < m_cnt; i++) nl.push_back(mdl[i]);
        end else begin
            lat = m_cnt;
            for (int i = 0; i < m_cnt; i++)
                if (mkeep(mdl[i], m) && mdl[i].f != '0) nl.push_back(mdl[i]);
        end
        ecnt_q.push_back(nl.size());
        elat_q.push_back(lat);
        etag_q.push_back(tag);
        foreach (nl[i]) exp_q.push_back(nl[i]);
        m_cnt = nl.size();
        for (int i = 0; i < m_cnt; i++) mdl[i] = nl[i];
        pending++;
        @(negedge clk);
        req_mask = m; start = 1;
        @(posedge clk);
        #1 start_cyc = cyc; start = 0;
        if (poke) begin
            @(negedge clk);
            start = 1; req_mask = '0; ld_valid = 1; ld_first = 1;
            ld_from = 16'hDEAD; ld_type = TU; ld_abort = 0;
            @(posedge clk);
            #1 start = 0; ld_valid = 0; ld_first = 0;
        end
        wait (pending == 0);
        @(negedge clk);
    endtask

    // monitor: pops the prediction on each done and compares
    initial begin
        rd_idx = '0;
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (ecnt_q.size() == 0) begin
                    chk("R10", "unexpected done", 1, 0);
                end else begin
                    int    ec, el;
                    string tg;
                    ec = ecnt_q.pop_front();
                    el = elat_q.pop_front();
                    tg = etag_q.pop_front();
                    chk(tg, "count", count, ec);
                    chk("R9", "latency", cyc - start_cyc, el);
                    for (int i = 0; i < DEPTH; i++) begin
                        rd_idx = IDX_W'(i);
                        #1;
                        if (i < ec) begin
                            rec_t e;
                            e = exp_q.pop_front();
                            chk(tg, "record", longint'({rd_from, rd_to, rd_intx, rd_abort, rd_type}), longint'(e));
                        end else begin
                            chk("R11", "beyond count", longint'({rd_from, rd_to, rd_intx, rd_abort, rd_type}), 0);
                        end
                    end
                    rd_idx = '0;
                    pending--;
                end
            end
        end
    end

    initial begin
        rst_n = 0; ld_valid = 0; ld_first = 0; ld_from = '0; ld_to = '0;
        ld_intx = 0; ld_abort = 0; ld_type = '0; dup_abort_en = 0;
        start = 0; req_mask = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "count", count, 0);
        chk("R12", "done", done, 0);
        chk("R12", "read", longint'(rd_type), 0);
        @(negedge clk); rst_n = 1;

        // full mask bypass
        ld(1, 16'h0101, 0, 0, TU | TCOND);
        ld(0, 16'h0102, 0, 0, TK | TCOND);
        ld(0, 16'h0103, 0, 0, TU | TRET);
        ld(0, 16'h0104, 0, 0, TU | TJMP);
        ld(0, 16'h0105, 0, 0, TU | TCOND);
        chk("R1", "count after loads", count, 5);
        run(FULLM, "R3", 0);
        run(18'h3FFFF, "R3", 0);
        // match rule and compaction
        run(TU | TCOND | TRET, "R4 R8", 0);

        // zero type always dropped
        ld(1, 16'h0201, 0, 0, TU | TCOND);
        ld(0, 16'h0202, 0, 0, '0);
        ld(0, 16'h0203, 0, 0, TU | TCOND);
        run(TU | TCOND, "R6", 0);

        // nothing dropped: zero source kept
        ld(1, 16'h0000, 0, 0, TU | TCOND);
        ld(0, 16'h0302, 0, 0, TU | TCOND);
        run(TU | TCOND, "R7", 0);
        // compaction also removes zero source
        ld(1, 16'h0000, 0, 0, TU | TCOND);
        ld(0, 16'h0312, 0, 0, TU | TRET);
        ld(0, 16'h0313, 0, 0, TU | TCOND);
        run(TU | TCOND, "R8", 0);

        // transaction tagging
        ld(1, 16'h0401, 1, 0, TU | TCOND);
        ld(0, 16'h0402, 0, 0, TU | TCOND);
        ld(0, 16'h0403, 1, 0, '0);
        ld(0, 16'h0404, 1, 0, TU | TCOND);
        run(TU | TCOND | TINTX, "R5", 0);

        // duplicate abort correction
        dup_abort_en = 1;
        ld(1, 16'h0501, 0, 0, TU | TCOND);
        ld(0, 16'h0502, 0, 1, TU | TCOND);
        ld(0, 16'h0503, 0, 0, TU | TCOND);
        chk("R2", "count overwrite", count, 2);
        run(FULLM, "R2", 0);
        ld(1, 16'h0511, 0, 1, TU | TCOND);
        chk("R2", "count first abort", count, 1);
        dup_abort_en = 0;
        ld(0, 16'h0512, 0, 1, TU | TCOND);
        chk("R2", "count append", count, 2);
        run(FULLM, "R2", 0);

        // overflow ignored
        ld(1, 16'h0600, 0, 0, TU);
        for (int i = 1; i < 10; i++) ld(0, ADDR_W'(16'h0600 + i), 0, 0, TU);
        chk("R1", "count saturates", count, DEPTH);
        run(FULLM, "R1", 0);

        // worst case with start and load poked mid-run
        ld(1, 16'h0701, 0, 0, TU | TCOND);
        for (int i = 1; i < DEPTH; i++)
            ld(0, ADDR_W'(16'h0701 + i), 0, 0, (i % 2 == 1) ? (TK | TCOND) : (TU | TCOND));
        run(TU | TCOND, "R10 R8", 1);

        // everything dropped
        ld(1, 16'h0801, 0, 0, TU | TCOND);
        ld(0, 16'h0802, 0, 0, TU | TRET);
        ld(0, 16'h0803, 0, 0, TU);
        run(TK | TCOND, "R8", 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule